// File: doc/BRIEF.md
# Byte-Lane Load/Store Aligner

This block sits between a 32-bit register file and a word-wide data memory. It takes a memory-access opcode, the low bits of the effective address, the register value to be stored and the word read from memory. For stores it works out which bytes of the memory word are written and copies the store value onto those lanes. For loads it picks the addressed byte, halfword or word out of the memory word and widens it to a full register, with sign or zero fill as the opcode asks.

Byte lanes are little-endian. The two address bits below the word boundary pick a byte lane. The upper of those two bits picks a halfword lane. A halfword access at an odd address is misaligned. A word access whose two low address bits are not zero is also misaligned. Either case raises an alignment fault, and a faulting access neither writes memory nor returns load data. The effective-address adder and the memory are outside this block. All outputs are registered and appear one clock after the request is presented.

Top module: `lane_align_unit`

## Requirements
- R1: During reset and on the first cycles after it, byteEn, wrData, loadData and alignFault are all zero.
- R2: Opcode 0x20 returns the byte on lane effAddrLow (lane k = memRdata bits 8k+7..8k), sign-extended to 32 bits. Opcode 0x24 returns the same byte zero-extended. A byte load never faults.
- R3: Opcode 0x21 returns the halfword on lane effAddrLow[1] (bits 15..0 when 0, bits 31..16 when 1), sign-extended. Opcode 0x25 returns it zero-extended.
- R4: Opcode 0x23 at a word-aligned address returns memRdata unchanged.
- R5: Opcode 0x28 sets exactly one byte enable, bit effAddrLow, and drives storeData[7:0] on all four lanes of wrData.
- R6: Opcode 0x29 at an even address sets byteEn to 4'b0011 when effAddrLow[1] is 0 and to 4'b1100 when it is 1, and drives storeData[15:0] on both halfword lanes.
- R7: Opcode 0x2B at a word-aligned address sets byteEn to 4'b1111 and wrData to storeData.
- R8: alignFault is raised for opcode 0x21, 0x25 or 0x29 with effAddrLow[0]=1, and for opcode 0x23 or 0x2B with effAddrLow not 0. While it is raised, byteEn, wrData and loadData are zero.
- R9: When accValid is 0, or the opcode is none of the eight above, every output is zero. Loads always leave byteEn zero.
- R10: Each output reflects the request sampled at the previous rising clock edge. An idle cycle after an access returns all outputs to zero one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | A memory access is presented this cycle |
| opCode | input | 6 | Primary opcode of the access |
| effAddrLow | input | 2 | Byte offset of the effective address within the word |
| storeData | input | 32 | Register value to be stored |
| memRdata | input | 32 | Word read from data memory |
| byteEn | output | 4 | Per-lane write enables, bit k for lane k |
| wrData | output | 32 | Store data placed on the lanes |
| loadData | output | 32 | Extended load result |
| alignFault | output | 1 | Misaligned halfword or word access |

## Verification
Lane selection and the alignment fault are decided in the same cycle, and the fault must win over enables that the lane logic has already computed. The bench provokes this overlap by sending every supported opcode at all four byte offsets, with data patterns whose sign bits differ between lanes. A reference model in the bench predicts all four outputs for every cycle, and misaligned cases are accepted only when the fault is set and enables, write data and load data are all zero. Idle cycles and unsupported opcodes are placed between accesses to show that nothing from a previous access carries over.

// File: rtl/lane_align_pkg.sv
package lane_align_pkg;

  localparam logic [5:0] OP_LD_BYTE_S = 6'h20;
  localparam logic [5:0] OP_LD_HALF_S = 6'h21;
  localparam logic [5:0] OP_LD_WORD   = 6'h23;
  localparam logic [5:0] OP_LD_BYTE_Z = 6'h24;
  localparam logic [5:0] OP_LD_HALF_Z = 6'h25;
  localparam logic [5:0] OP_ST_BYTE   = 6'h28;
  localparam logic [5:0] OP_ST_HALF   = 6'h29;
  localparam logic [5:0] OP_ST_WORD   = 6'h2B;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } accSize_t;

  // Strobes from decode to the lane datapath
  typedef struct packed {
    logic     isLoad;
    logic     isStore;
    accSize_t size;
    logic     signExt;
    logic     fault;
  } laneStrobes_t;

endpackage

// File: rtl/lane_align_ctrl.sv
module lane_align_ctrl
  import lane_align_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  logic             accValid,
  input  logic [5:0]       opCode,
  input  logic [OFF_W-1:0] addrLow,
  output laneStrobes_t     strb
);

  logic     isLd;
  logic     isSt;
  accSize_t sz;
  logic     sExt;

  always_comb begin
    isLd = 1'b0;
    isSt = 1'b0;
    sz   = SZ_BYTE;
    sExt = 1'b0;
    unique case (opCode)
      OP_LD_BYTE_S: begin isLd = 1'b1; sz = SZ_BYTE; sExt = 1'b1; end
      OP_LD_BYTE_Z: begin isLd = 1'b1; sz = SZ_BYTE; end
      OP_LD_HALF_S: begin isLd = 1'b1; sz = SZ_HALF; sExt = 1'b1; end
      OP_LD_HALF_Z: begin isLd = 1'b1; sz = SZ_HALF; end
      OP_LD_WORD:   begin isLd = 1'b1; sz = SZ_WORD; end
      OP_ST_BYTE:   begin isSt = 1'b1; sz = SZ_BYTE; end
      OP_ST_HALF:   begin isSt = 1'b1; sz = SZ_HALF; end
      OP_ST_WORD:   begin isSt = 1'b1; sz = SZ_WORD; end
      default: ;
    endcase
  end

  logic misaligned;
  always_comb begin
    unique case (sz)
      SZ_HALF: misaligned = addrLow[0];
      SZ_WORD: misaligned = (addrLow != '0);
      default: misaligned = 1'b0;
    endcase
  end

  always_comb begin
    strb.isLoad  = accValid & isLd;
    strb.isStore = accValid & isSt;
    strb.size    = sz;
    strb.signExt = sExt;
    strb.fault   = accValid & (isLd | isSt) & misaligned;
  end

endmodule

// File: rtl/lane_align_dp.sv
module lane_align_dp
  import lane_align_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  laneStrobes_t               strb,
  input  logic [$clog2(DATA_W/8)-1:0] addrLow,
  input  logic [DATA_W-1:0]          storeData,
  input  logic [DATA_W-1:0]          memRdata,
  output logic [DATA_W/8-1:0]        byteEn,
  output logic [DATA_W-1:0]          wrData,
  output logic [DATA_W-1:0]          loadData,
  output logic                       alignFault
);

  localparam int LANES  = DATA_W / 8;
  localparam int HALVES = LANES / 2;
  localparam int OFF_W  = $clog2(LANES);

  // Load extraction
  logic [OFF_W-1:0] halfOff;
  logic [7:0]       byteVal;
  logic [15:0]      halfVal;
  assign halfOff = {addrLow[OFF_W-1:1], 1'b0};
  assign byteVal = 8'(memRdata >> {addrLow, 3'b000});
  assign halfVal = 16'(memRdata >> {halfOff, 3'b000});

  logic [DATA_W-1:0] ldNext;
  always_comb begin
    ldNext = '0;
    if (strb.isLoad && !strb.fault) begin
      unique case (strb.size)
        SZ_BYTE: ldNext = strb.signExt ? {{(DATA_W-8){byteVal[7]}}, byteVal}
                                       : {{(DATA_W-8){1'b0}}, byteVal};
        SZ_HALF: ldNext = strb.signExt ? {{(DATA_W-16){halfVal[15]}}, halfVal}
                                       : {{(DATA_W-16){1'b0}}, halfVal};
        default: ldNext = memRdata;
      endcase
    end
  end

  // Store lane enables, one per lane
  logic [LANES-1:0] laneHit;
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign laneHit[i] = (strb.size == SZ_BYTE) ? (addrLow == OFF_W'(i)) :
                        (strb.size == SZ_HALF) ? (addrLow[OFF_W-1:1] == (OFF_W-1)'(i / 2)) :
                        1'b1;
  end

  logic [LANES-1:0]  beNext;
  logic [DATA_W-1:0] wdNext;
  always_comb begin
    beNext = '0;
    wdNext = '0;
    if (strb.isStore && !strb.fault) begin
      beNext = laneHit;
      unique case (strb.size)
        SZ_BYTE: wdNext = {LANES{storeData[7:0]}};
        SZ_HALF: wdNext = {HALVES{storeData[15:0]}};
        default: wdNext = storeData;
      endcase
    end
  end

  logic pastOk;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteEn     <= '0;
      wrData     <= '0;
      loadData   <= '0;
      alignFault <= 1'b0;
      pastOk     <= 1'b0;
    end else begin
      byteEn     <= beNext;
      wrData     <= wdNext;
      loadData   <= ldNext;
      alignFault <= strb.fault;
      pastOk     <= 1'b1;
    end
  end

  // A raised fault suppresses every lane and the load result
  assert_fault_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    alignFault |-> (byteEn == '0 && loadData == '0 && wrData == '0));

  assert_byte_onehot_R5: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && $past(strb.isStore && strb.size == SZ_BYTE && !strb.fault)
      |-> $onehot(byteEn));

  assert_half_pair_R6: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && $past(strb.isStore && strb.size == SZ_HALF && !strb.fault)
      |-> ($countones(byteEn) == 2));

  assert_word_all_R7: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && $past(strb.isStore && strb.size == SZ_WORD && !strb.fault)
      |-> (&byteEn));

  assert_load_nowrite_R9: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && $past(!strb.isStore) |-> (byteEn == '0));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && $past(!strb.isStore && !strb.isLoad)
      |-> (byteEn == '0 && loadData == '0 && !alignFault));

endmodule

// File: rtl/lane_align_unit.sv
module lane_align_unit
  import lane_align_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        accValid,
  input  logic [5:0]                  opCode,
  input  logic [$clog2(DATA_W/8)-1:0] effAddrLow,
  input  logic [DATA_W-1:0]           storeData,
  input  logic [DATA_W-1:0]           memRdata,
  output logic [DATA_W/8-1:0]         byteEn,
  output logic [DATA_W-1:0]           wrData,
  output logic [DATA_W-1:0]           loadData,
  output logic                        alignFault
);

  localparam int OFF_W = $clog2(DATA_W / 8);

  laneStrobes_t strb;

  lane_align_ctrl #(.OFF_W(OFF_W)) u_ctrl (
    .accValid (accValid),
    .opCode   (opCode),
    .addrLow  (effAddrLow),
    .strb     (strb)
  );

  lane_align_dp #(.DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .addrLow    (effAddrLow),
    .storeData  (storeData),
    .memRdata   (memRdata),
    .byteEn     (byteEn),
    .wrData     (wrData),
    .loadData   (loadData),
    .alignFault (alignFault)
  );

endmodule

// File: tb/sim_lane_align_unit.sv
module sim_lane_align_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accValid = 1'b0;
  logic [5:0]  opCode = '0;
  logic [1:0]  effAddrLow = '0;
  logic [31:0] storeData = '0;
  logic [31:0] memRdata = '0;
  logic [3:0]  byteEn;
  logic [31:0] wrData;
  logic [31:0] loadData;
  logic        alignFault;

  always #2.5 clk = ~clk;

  lane_align_unit u0 (
    .clk(clk), .rstN(rstN), .accValid(accValid), .opCode(opCode),
    .effAddrLow(effAddrLow), .storeData(storeData), .memRdata(memRdata),
    .byteEn(byteEn), .wrData(wrData), .loadData(loadData), .alignFault(alignFault)
  );

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [3:0]  expBe = '0;
  logic [31:0] expWd = '0;
  logic [31:0] expLd = '0;
  bit          expF = 1'b0;
  string       expTag = "R1";
  bit          prevAccess = 1'b0;

  function automatic void refModel(input bit v, input logic [5:0] op, input logic [1:0] off,
                                   input logic [31:0] sd, input logic [31:0] rd,
                                   output logic [3:0] be, output logic [31:0] wd,
                                   output logic [31:0] ld, output bit f, output string tag);
    logic [7:0]  b;
    logic [15:0] h;
    be = '0; wd = '0; ld = '0; f = 1'b0; tag = "R9";
    b = rd[8*off +: 8];
    h = rd[16*off[1] +: 16];
    if (!v) return;
    case (op)
      6'h20: begin tag = "R2"; ld = {{24{b[7]}}, b}; end
      6'h24: begin tag = "R2"; ld = {24'h0, b}; end
      6'h21: if (off[0]) begin f = 1'b1; tag = "R8"; end
             else begin tag = "R3"; ld = {{16{h[15]}}, h}; end
      6'h25: if (off[0]) begin f = 1'b1; tag = "R8"; end
             else begin tag = "R3"; ld = {16'h0, h}; end
      6'h23: if (off != 2'd0) begin f = 1'b1; tag = "R8"; end
             else begin tag = "R4"; ld = rd; end
      6'h28: begin tag = "R5"; be = 4'b0001 << off; wd = {4{sd[7:0]}}; end
      6'h29: if (off[0]) begin f = 1'b1; tag = "R8"; end
             else begin tag = "R6"; be = off[1] ? 4'b1100 : 4'b0011; wd = {2{sd[15:0]}}; end
      6'h2B: if (off != 2'd0) begin f = 1'b1; tag = "R8"; end
             else begin tag = "R7"; be = 4'hF; wd = sd; end
      default: ;
    endcase
  endfunction

  task automatic compareOut();
    checks++;
    if (byteEn !== expBe) begin errors++;
      $display("FAIL %s byteEn actual=%b expected=%b", expTag, byteEn, expBe); end
    checks++;
    if (wrData !== expWd) begin errors++;
      $display("FAIL %s wrData actual=%h expected=%h", expTag, wrData, expWd); end
    checks++;
    if (loadData !== expLd) begin errors++;
      $display("FAIL %s loadData actual=%h expected=%h", expTag, loadData, expLd); end
    checks++;
    if (alignFault !== expF) begin errors++;
      $display("FAIL %s alignFault actual=%b expected=%b", expTag, alignFault, expF); end
  endtask

  // Check the previous cycle's prediction, then present a new request
  task automatic step(input bit v, input logic [5:0] op, input logic [1:0] off,
                      input logic [31:0] sd, input logic [31:0] rd);
    string t;
    @(negedge clk);
    compareOut();
    accValid = v; opCode = op; effAddrLow = off; storeData = sd; memRdata = rd;
    refModel(v, op, off, sd, rd, expBe, expWd, expLd, expF, t);
    if (t == "R9" && prevAccess) t = "R10";
    expTag = t;
    prevAccess = (t != "R9" && t != "R10");
  endtask

  initial begin
    logic [5:0]  ops [10] = '{6'h20, 6'h24, 6'h21, 6'h25, 6'h23,
                              6'h28, 6'h29, 6'h2B, 6'h00, 6'h22};
    logic [31:0] sds [3]  = '{32'h8765_43A9, 32'h1234_F678, 32'hFFFF_0000};
    logic [31:0] rds [3]  = '{32'h80FF_7F01, 32'hA5C3_3C5A, 32'h0000_8000};
    repeat (3) @(negedge clk);
    // R1: outputs held at zero in reset
    compareOut();
    rstN = 1'b1;
    step(1'b0, 6'h00, 2'd0, '0, '0);
    for (int d = 0; d < 3; d++) begin
      for (int o = 0; o < 10; o++) begin
        for (int a = 0; a < 4; a++) begin
          step(1'b1, ops[o], 2'(a), sds[d], rds[d]);
        end
        step(1'b0, ops[o], 2'd1, sds[d], rds[d]);
      end
    end
    // Back-to-back misaligned then aligned store to the same lanes
    step(1'b1, 6'h2B, 2'd3, 32'hDEAD_BEEF, 32'h0);
    step(1'b1, 6'h2B, 2'd0, 32'hDEAD_BEEF, 32'h0);
    step(1'b1, 6'h29, 2'd1, 32'hCAFE_1234, 32'h0);
    step(1'b1, 6'h21, 2'd2, 32'h0, 32'h7FFF_8001);
    step(1'b0, 6'h00, 2'd0, '0, '0);
    step(1'b0, 6'h00, 2'd0, '0, '0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule